// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint Buffer

This block holds outgoing packet data for a single USB IN endpoint. Firmware pushes bytes one at a time through a data port. It then commits the packet by writing its byte count in two 8-bit halves. The USB-side engine reads the committed bytes out in order and reports how each transaction ended: it pulses a success input when the host acknowledged the packet, or a failure input for an underrun or a missing handshake.

Storage is split into two equal data sets. Firmware can fill one set while the USB side is still sending or retrying the other. A successful transaction releases the set being sent and moves the reader to the other set. On a non-isochronous endpoint a failure rewinds the reader to the first byte, so the same packet can be sent again. On an isochronous endpoint a failure releases the set just as a success does. For non-isochronous traffic, a hold input lets firmware stop the hardware from switching sets: a successful transaction then rewinds and keeps the set instead of releasing it.

Top module: `tx_dual_buf`

## Requirements
- R1: While `rst_n` is low, and on the cycle after, `usb_ready`, `fw_full` and `usb_underrun` are all 0.
- R2: Each accepted firmware data write stores one byte at the next position of the write set. The USB side reads the bytes back in the order they were written. Each read of an available byte lowers `usb_left` by exactly one.
- R3: The count takes effect only on a low-byte write (`fw_cnt_lo_we`). Its value is {last high byte written, low byte}, and the high byte keeps its value from one commit to the next. A high-byte write alone does not mark a set ready. A count larger than `SET_BYTES` is reduced to `SET_BYTES`.
- R4: After a commit, the other set takes firmware writes. `fw_full` is 1 while the set open to firmware still holds a committed packet. While `fw_full` is 1, data writes and commits are ignored.
- R5: A success pulse (`usb_ok`) on a ready set releases it and moves the reader to the other set, with `usb_left` then equal to that set's count. This does not apply when `ovr_hold` is set on a non-isochronous endpoint.
- R6: A failure pulse (`usb_fail`) with `usb_iso`=0 keeps the set ready and rewinds the reader to its first byte.
- R7: A failure pulse with `usb_iso`=1 releases the set and advances, exactly as a success does.
- R8: With `ovr_hold`=1 and `usb_iso`=0, a success pulse keeps the set ready and rewinds the reader instead of switching sets.
- R9: When the set under the reader has not been committed, `usb_ready` is 0, so the USB side can refuse the request.
- R10: A read with `usb_left`=0 or `usb_ready`=0 raises `usb_underrun` for one cycle on the next cycle and leaves the read position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_wr_en | input | 1 | Firmware data write strobe |
| fw_wr_data | input | DATA_W | Firmware data byte |
| fw_cnt_hi_we | input | 1 | Write the high byte of the count |
| fw_cnt_lo_we | input | 1 | Write the low byte of the count and commit the set |
| fw_cnt_byte | input | 8 | Count byte for either half |
| fw_full | output | 1 | Set open to firmware still holds a committed packet |
| usb_iso | input | 1 | Endpoint is isochronous |
| ovr_hold | input | 1 | Firmware override: keep the current set on success (non-isochronous only) |
| usb_rd_en | input | 1 | USB side reads one byte |
| usb_rd_data | output | DATA_W | Byte at the current read position |
| usb_ok | input | 1 | Transaction acknowledged |
| usb_fail | input | 1 | Transaction failed (underrun or no handshake) |
| usb_ready | output | 1 | Set under the reader is committed |
| usb_len | output | 16 | Committed byte count of the set under the reader |
| usb_left | output | 16 | Bytes not yet read from that set |
| usb_underrun | output | 1 | One-cycle pulse after a read with no byte available |

## Verification
A wrong set pointer shows up at once as a wrong `usb_len` or as bytes from another packet on `usb_rd_data`, starting on the first read after the faulty transition. A ready flag that was not cleared or not set shows up as `fw_full` or `usb_ready` holding the wrong value one cycle after the commit or release pulse. A read pointer that did not rewind shows up as a `usb_left` value below the packet length, and as the wrong first byte on the retry. A clamp or high-byte latch fault appears in `usb_len` on the cycle after the low-byte write.

// File: rtl/tx_dual_buf_pkg.sv
// Package tx_dual_buf_pkg
// Shared constants, types and helpers for the dual-set transmit buffer.
// Assumes exactly two data sets; the count is always 16 bits.
package tx_dual_buf_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // Per-set bookkeeping held by the top module.
    typedef struct packed {
        logic ready;
        cnt_t len;
    } set_state_t;

    // Clamp a requested count to the capacity of one set.
    function automatic cnt_t clamp_len(input cnt_t req, input cnt_t cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/tx_dual_buf_store.sv
// Module tx_dual_buf_store
// Byte storage for two data sets with one write and one read port.
// Assumes SET_BYTES is a power of two. The read is combinational and
// returns zero for a position at or beyond the end of a set.
module tx_dual_buf_store #(
    parameter int DATA_W    = 8,
    parameter int SET_BYTES = 64,
    localparam int SW       = $clog2(SET_BYTES),
    localparam int PTR_W    = SW + 1,
    localparam int DEPTH    = 2 * SET_BYTES
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_set,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_set,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte at {set, position}.
    always_ff @(posedge clk) begin
        if (wr_en && !wr_ptr[SW]) begin
            mem[{wr_set, wr_ptr[SW-1:0]}] <= wr_data;
        end
    end

    // Present the byte under the read position.
    always_comb begin
        if (rd_ptr[SW]) begin
            rd_data = '0;
        end else begin
            rd_data = mem[{rd_set, rd_ptr[SW-1:0]}];
        end
    end

endmodule

// File: rtl/tx_dual_buf_fill.sv
// Module tx_dual_buf_fill
// Firmware-side writer. It tracks the set open to firmware and the write
// position in it, latches the count high byte, and commits the set on a
// low-byte write. Assumes set_busy reflects the ready flag of wr_set.
module tx_dual_buf_fill
    import tx_dual_buf_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SET_BYTES = 64,
    localparam int SW       = $clog2(SET_BYTES),
    localparam int PTR_W    = SW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [7:0]        cnt_byte,
    input  logic              set_busy,
    output logic              wr_set,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_ptr,
    output logic [DATA_W-1:0] mem_data,
    output logic              commit,
    output cnt_t              commit_len
);

    localparam cnt_t CAP = cnt_t'(SET_BYTES);

    logic [PTR_W-1:0] wr_ptr;
    logic [7:0]       hi_q;

    // Decode accepted writes and the commit request.
    always_comb begin
        mem_we     = wr_en && !set_busy && (wr_ptr < PTR_W'(SET_BYTES));
        mem_ptr    = wr_ptr;
        mem_data   = wr_data;
        commit     = lo_we && !set_busy;
        commit_len = clamp_len({hi_q, cnt_byte}, CAP);
    end

    // Advance the write position and switch sets on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            wr_set <= 1'b0;
        end else if (commit) begin
            wr_ptr <= '0;
            wr_set <= ~wr_set;
        end else if (mem_we) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Keep the last high count byte written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_we) begin
            hi_q <= cnt_byte;
        end
    end

endmodule

// File: rtl/tx_dual_buf_drain.sv
// Module tx_dual_buf_drain
// USB-side reader. It tracks the set being sent and the read position,
// flags underruns, and decides between release and rewind when a
// transaction ends. Assumes cur_ready and cur_len describe rd_set.
module tx_dual_buf_drain
    import tx_dual_buf_pkg::*;
#(
    parameter int SET_BYTES = 64,
    localparam int SW       = $clog2(SET_BYTES),
    localparam int PTR_W    = SW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             done_ok,
    input  logic             done_fail,
    input  logic             iso,
    input  logic             hold,
    input  logic             cur_ready,
    input  cnt_t             cur_len,
    output logic             rd_set,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             release_set,
    output logic             underrun
);

    logic hold_eff;
    logic byte_avail;

    // Decide the end-of-transaction action and whether a byte is available.
    always_comb begin
        hold_eff    = hold && !iso;
        release_set = cur_ready && ((done_ok && !hold_eff) || (done_fail && iso));
        byte_avail  = cur_ready && (cnt_t'(rd_ptr) < cur_len);
    end

    // Move the read position, switch sets, and flag underruns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rd_set   <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (done_ok || done_fail) begin
                rd_ptr <= '0;
                if (release_set) begin
                    rd_set <= ~rd_set;
                end
            end else if (rd_en) begin
                if (byte_avail) begin
                    rd_ptr <= rd_ptr + 1'b1;
                end else begin
                    underrun <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tx_dual_buf.sv
// Module tx_dual_buf
// Double-buffered transmit buffer for one IN endpoint. Firmware fills a set
// and commits it with a two-part byte count. The USB side reads it out and
// reports each transaction's outcome. Assumes SET_BYTES is a power of two.
module tx_dual_buf
    import tx_dual_buf_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SET_BYTES = 64,
    localparam int SW       = $clog2(SET_BYTES),
    localparam int PTR_W    = SW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fw_wr_en,
    input  logic [DATA_W-1:0] fw_wr_data,
    input  logic              fw_cnt_hi_we,
    input  logic              fw_cnt_lo_we,
    input  logic [7:0]        fw_cnt_byte,
    output logic              fw_full,
    input  logic              usb_iso,
    input  logic              ovr_hold,
    input  logic              usb_rd_en,
    output logic [DATA_W-1:0] usb_rd_data,
    input  logic              usb_ok,
    input  logic              usb_fail,
    output logic              usb_ready,
    output logic [15:0]       usb_len,
    output logic [15:0]       usb_left,
    output logic              usb_underrun
);

    set_state_t       st [2];
    logic             wr_set, rd_set;
    logic             mem_we, commit, release_set;
    logic [PTR_W-1:0] mem_ptr, rd_ptr;
    logic [DATA_W-1:0] mem_data;
    cnt_t             commit_len;

    tx_dual_buf_fill #(.DATA_W(DATA_W), .SET_BYTES(SET_BYTES)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fw_wr_en),
        .wr_data    (fw_wr_data),
        .hi_we      (fw_cnt_hi_we),
        .lo_we      (fw_cnt_lo_we),
        .cnt_byte   (fw_cnt_byte),
        .set_busy   (st[wr_set].ready),
        .wr_set     (wr_set),
        .mem_we     (mem_we),
        .mem_ptr    (mem_ptr),
        .mem_data   (mem_data),
        .commit     (commit),
        .commit_len (commit_len)
    );

    tx_dual_buf_drain #(.SET_BYTES(SET_BYTES)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (usb_rd_en),
        .done_ok     (usb_ok),
        .done_fail   (usb_fail),
        .iso         (usb_iso),
        .hold        (ovr_hold),
        .cur_ready   (st[rd_set].ready),
        .cur_len     (st[rd_set].len),
        .rd_set      (rd_set),
        .rd_ptr      (rd_ptr),
        .release_set (release_set),
        .underrun    (usb_underrun)
    );

    tx_dual_buf_store #(.DATA_W(DATA_W), .SET_BYTES(SET_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_set  (wr_set),
        .wr_ptr  (mem_ptr),
        .wr_data (mem_data),
        .rd_set  (rd_set),
        .rd_ptr  (rd_ptr),
        .rd_data (usb_rd_data)
    );

    // Mark sets ready on commit and free them on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                st[s] <= '0;
            end
        end else begin
            for (int s = 0; s < 2; s++) begin
                if (commit && (wr_set == s[0])) begin
                    st[s].ready <= 1'b1;
                    st[s].len   <= commit_len;
                end else if (release_set && (rd_set == s[0])) begin
                    st[s].ready <= 1'b0;
                end
            end
        end
    end

    // Drive status seen by both sides.
    always_comb begin
        fw_full   = st[wr_set].ready;
        usb_ready = st[rd_set].ready;
        usb_len   = st[rd_set].len;
        usb_left  = st[rd_set].len - cnt_t'(rd_ptr);
    end

endmodule

// File: rtl/tx_dual_buf_chk.sv
// Module tx_dual_buf_chk
// Port-level properties of tx_dual_buf, bound to every instance.
module tx_dual_buf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        usb_rd_en,
    input logic        usb_ok,
    input logic        usb_fail,
    input logic        usb_iso,
    input logic        ovr_hold,
    input logic        usb_ready,
    input logic [15:0] usb_len,
    input logic [15:0] usb_left,
    input logic        usb_underrun,
    input logic        fw_full
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!usb_ready && !fw_full && !usb_underrun));

    assert_read_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_rd_en && !usb_ok && !usb_fail && usb_ready && usb_left != 16'd0)
        |=> (usb_left == $past(usb_left) - 16'd1) && !usb_underrun);

    assert_full_implies_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fw_full |-> usb_ready);

    assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_ok && usb_ready && !(ovr_hold && !usb_iso)) |=> !fw_full);

    assert_fail_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_fail && !usb_ok && !usb_iso && usb_ready)
        |=> usb_ready && (usb_left == $past(usb_len)));

    assert_iso_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_fail && usb_iso && usb_ready) |=> !fw_full);

    assert_hold_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_ok && ovr_hold && !usb_iso && usb_ready)
        |=> usb_ready && (usb_left == $past(usb_len)));

    assert_underrun_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        usb_underrun |-> $past(usb_rd_en) && ($past(!usb_ready) || $past(usb_left) == 16'd0));

endmodule

bind tx_dual_buf tx_dual_buf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .usb_rd_en    (usb_rd_en),
    .usb_ok       (usb_ok),
    .usb_fail     (usb_fail),
    .usb_iso      (usb_iso),
    .ovr_hold     (ovr_hold),
    .usb_ready    (usb_ready),
    .usb_len      (usb_len),
    .usb_left     (usb_left),
    .usb_underrun (usb_underrun),
    .fw_full      (fw_full)
);

// File: tb/tx_dual_buf_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the fill task queues expected bytes and the read task
// pops and compares them as the design presents them.
module tx_dual_buf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fw_wr_en = 1'b0;
    logic [7:0]  fw_wr_data = '0;
    logic        fw_cnt_hi_we = 1'b0;
    logic        fw_cnt_lo_we = 1'b0;
    logic [7:0]  fw_cnt_byte = '0;
    logic        fw_full;
    logic        usb_iso = 1'b0;
    logic        ovr_hold = 1'b0;
    logic        usb_rd_en = 1'b0;
    logic [7:0]  usb_rd_data;
    logic        usb_ok = 1'b0;
    logic        usb_fail = 1'b0;
    logic        usb_ready;
    logic [15:0] usb_len;
    logic [15:0] usb_left;
    logic        usb_underrun;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];

    typedef enum int {END_OK, END_FAIL} end_e;

    always #2.5 clk = ~clk;

    tx_dual_buf uut (
        .clk(clk), .rst_n(rst_n),
        .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
        .fw_cnt_hi_we(fw_cnt_hi_we), .fw_cnt_lo_we(fw_cnt_lo_we),
        .fw_cnt_byte(fw_cnt_byte), .fw_full(fw_full),
        .usb_iso(usb_iso), .ovr_hold(ovr_hold),
        .usb_rd_en(usb_rd_en), .usb_rd_data(usb_rd_data),
        .usb_ok(usb_ok), .usb_fail(usb_fail),
        .usb_ready(usb_ready), .usb_len(usb_len),
        .usb_left(usb_left), .usb_underrun(usb_underrun)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: write one byte; queue it when the design must accept it.
    task automatic put_byte(input logic [7:0] b, input bit expect_kept);
        fw_wr_en = 1'b1;
        fw_wr_data = b;
        @(negedge clk);
        fw_wr_en = 1'b0;
        if (expect_kept) exp_q.push_back(b);
    endtask

    task automatic put_hi(input logic [7:0] b);
        fw_cnt_hi_we = 1'b1;
        fw_cnt_byte = b;
        @(negedge clk);
        fw_cnt_hi_we = 1'b0;
    endtask

    task automatic put_lo(input logic [7:0] b);
        fw_cnt_lo_we = 1'b1;
        fw_cnt_byte = b;
        @(negedge clk);
        fw_cnt_lo_we = 1'b0;
    endtask

    task automatic end_txn(input end_e how);
        if (how == END_OK) usb_ok = 1'b1; else usb_fail = 1'b1;
        @(negedge clk);
        usb_ok = 1'b0;
        usb_fail = 1'b0;
    endtask

    // Monitor: read n bytes and compare against the queue head; a released
    // packet is popped, a kept one stays queued for its retry.
    task automatic take_pkt(input int n, input end_e how, input bit released, input string req);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            if (i >= exp_q.size() || usb_rd_data != exp_q[i]) begin
                errs++;
                if (i < exp_q.size())
                    $display("FAIL %s: byte %0d actual=%0d expected=%0d", req, i, usb_rd_data, exp_q[i]);
            end
            usb_rd_en = 1'b1;
            @(negedge clk);
            usb_rd_en = 1'b0;
        end
        chk(errs == 0, req, errs, 0);
        end_txn(how);
        if (released) begin
            for (int i = 0; i < n; i++) void'(exp_q.pop_front());
        end
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!usb_ready && !fw_full && !usb_underrun, "R1", {usb_ready, fw_full, usb_underrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!usb_ready && !fw_full, "R1", {usb_ready, fw_full}, 0);

        // R9/R10: a read with nothing committed flags underrun
        chk(usb_ready == 1'b0, "R9", usb_ready, 0);
        usb_rd_en = 1'b1;
        @(negedge clk);
        usb_rd_en = 1'b0;
        chk(usb_underrun == 1'b1, "R9", usb_underrun, 1);

        // Packet A into set 0; a high byte alone must not commit (R3)
        for (int i = 0; i < 5; i++) put_byte(8'h10 + 8'(i), 1'b1);
        put_hi(8'h00);
        chk(usb_ready == 1'b0, "R3", usb_ready, 0);
        put_lo(8'd5);
        chk(usb_ready && usb_len == 16'd5 && usb_left == 16'd5, "R3", usb_len, 5);
        chk(fw_full == 1'b0, "R4", fw_full, 0);

        // Packet B into set 1 while A waits (R4)
        for (int i = 0; i < 3; i++) put_byte(8'h20 + 8'(i), 1'b1);
        put_lo(8'd3);
        chk(fw_full == 1'b1, "R4", fw_full, 1);
        put_byte(8'hEE, 1'b0);   // ignored: both sets are committed (R4)

        // A fails: rewind and resend (R6), then succeeds (R5)
        take_pkt(5, END_FAIL, 1'b0, "R2");
        chk(usb_ready && usb_left == 16'd5 && usb_len == 16'd5, "R6", usb_left, 5);
        take_pkt(5, END_OK, 1'b1, "R6");
        chk(usb_ready && usb_len == 16'd3 && usb_left == 16'd3, "R5", usb_len, 3);
        chk(fw_full == 1'b0, "R5", fw_full, 0);

        // B with hold: success keeps the set and rewinds (R8)
        ovr_hold = 1'b1;
        take_pkt(3, END_OK, 1'b0, "R8");
        ovr_hold = 1'b0;
        chk(usb_ready && usb_len == 16'd3 && usb_left == 16'd3, "R8", usb_left, 3);

        // Packet C into the freed set 0; the earlier ignored byte must not show (R4)
        put_byte(8'h30, 1'b1);
        put_byte(8'h31, 1'b1);
        put_lo(8'd2);
        take_pkt(3, END_OK, 1'b1, "R5");
        chk(usb_ready && usb_len == 16'd2, "R5", usb_len, 2);

        // C read out, then one read too many (R10)
        for (int i = 0; i < 2; i++) begin
            chk(usb_rd_data == exp_q[i], "R4", usb_rd_data, exp_q[i]);
            usb_rd_en = 1'b1;
            @(negedge clk);
            usb_rd_en = 1'b0;
        end
        chk(usb_underrun == 1'b0 && usb_left == 16'd0, "R10", usb_left, 0);
        usb_rd_en = 1'b1;
        @(negedge clk);
        usb_rd_en = 1'b0;
        chk(usb_underrun == 1'b1 && usb_left == 16'd0, "R10", usb_underrun, 1);
        @(negedge clk);
        chk(usb_underrun == 1'b0, "R10", usb_underrun, 0);

        // Isochronous failure releases the set (R7)
        usb_iso = 1'b1;
        end_txn(END_FAIL);
        usb_iso = 1'b0;
        void'(exp_q.pop_front());
        void'(exp_q.pop_front());
        chk(usb_ready == 1'b0, "R7", usb_ready, 0);

        // Oversized count is clamped and extra writes are dropped (R2, R3)
        for (int i = 0; i < 66; i++) put_byte(8'h40 + 8'(i), i < 64);
        put_hi(8'h01);
        put_lo(8'h00);
        chk(usb_ready && usb_len == 16'd64, "R3", usb_len, 64);
        take_pkt(64, END_OK, 1'b1, "R2");
        chk(usb_ready == 1'b0, "R5", usb_ready, 0);

        // High byte persists across commits (R3): {01,04} clamps to 64
        for (int i = 0; i < 4; i++) put_byte(8'h70 + 8'(i), 1'b0);
        put_lo(8'd4);
        chk(usb_ready && usb_len == 16'd64, "R3", usb_len, 64);
        usb_iso = 1'b1;
        end_txn(END_FAIL);
        usb_iso = 1'b0;
        chk(usb_ready == 1'b0 && fw_full == 1'b0, "R7", usb_ready, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule